// File: doc/BRIEF.md
# Quadrature Position Decoder

The block turns the three signals of an incremental encoder (phase A, phase B and the once-per-turn index) into a signed-direction step stream and keeps a programmable position count. The raw pins are synchronised. They then pass through an optional glitch filter, an optional A/B exchange and a decoder that counts at one, two or four steps per encoder cycle. A timer mode uses A as a plain count clock and B as an up/down level.

The position register can be loaded at any time. It wraps at a programmed maximum, or is cleared by every index pulse. It can be confined to its low 16 bits. Single-cycle pulses report a wrap at either extreme and an arrival at a programmed match value. A status pin shows the direction in force. All control values are plain input levels held by the surrounding register file. There is no data stream at the edge of the block, so no valid/ready handshake applies.

Top module: `qdec_position`

## Requirements
- R1: `dec_mode` selects counting: 0 counts each rising A edge, 1 counts every A edge, 2 counts every single-phase change of A or B, 3 counts nothing. A step counts up when the previous decoded A equals the present decoded B, so A leading B counts up.
- R2: With `swap_ab` high, A and B are exchanged before decoding, so a sequence that counts up without the exchange counts down with it.
- R3: With `dir_src_reg` high, every step moves in the direction of `dir_set_up` (1 = up) and `dir_up` shows `dir_set_up`. With it low, the decoded direction is used.
- R4: With `timer_mode` high, each rising edge of decoded A is one step and the level of decoded B gives its direction (1 = up). B edges and falling A edges count nothing.
- R5: With `idx_clear_en` low, an up step from the maximum gives 0 and a down step from 0 gives the maximum. Each of these raises `wrap_pulse` for exactly one cycle.
- R6: With `idx_clear_en` high, a rising index edge clears the count to 0 without a wrap pulse. The extreme for wrapping is then the full active width (all ones).
- R7: With `narrow16` high, only the low 16 bits of the count, the load value and the maximum take part. A load of 0x12345678 reads back as 0x00005678, and a down step from 0 with index clearing enabled gives 0x0000FFFF.
- R8: `load_stb` writes `load_val` into the count and wins over a decoded step or an index clear in the same cycle.
- R9: `match_pulse` is high for one cycle when the count changes to a value equal to `match_val` (masked to the active width).
- R10: When `filt_bypass` is low, the inputs are sampled once every 2^n clocks (n = `filt_div`, values above 10 act as 10). A new level is accepted only after three consecutive samples agree, so a pulse shorter than the sample spacing has no effect on the count.
- R11: `soft_rst` clears the count and both pulses at the next edge, sets the decoded direction to up and ignores any step in that cycle.
- R12: With the filter bypassed, a pin change driven between edges moves the count at the fourth following rising clock edge: two synchronizer flops, one filter flop and the counter.
- R13: After reset the count is 0, both pulses are low and the decoded direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of count and decoder state |
| enc_a | input | 1 | Encoder phase A pin |
| enc_b | input | 1 | Encoder phase B pin |
| enc_idx | input | 1 | Encoder index pin |
| filt_bypass | input | 1 | 1 = glitch filter skipped |
| filt_div | input | 4 | Filter sample spacing exponent n (1:2^n) |
| swap_ab | input | 1 | Exchange A and B before decoding |
| timer_mode | input | 1 | A is count clock, B is direction level |
| dec_mode | input | 2 | 0 = 1x, 1 = 2x, 2 = 4x, 3 = idle |
| dir_src_reg | input | 1 | 1 = direction from `dir_set_up` |
| dir_set_up | input | 1 | Forced direction, 1 = up |
| idx_clear_en | input | 1 | 1 = index clears the count |
| narrow16 | input | 1 | 1 = 16-bit counting |
| load_stb | input | 1 | Load strobe |
| load_val | input | 32 | Value written on load |
| max_val | input | 32 | Wrap maximum |
| match_val | input | 32 | Match compare value |
| pos_cnt | output | 32 | Position count |
| wrap_pulse | output | 1 | One-cycle wrap flag |
| match_pulse | output | 1 | One-cycle match flag |
| dir_up | output | 1 | Direction in force, 1 = up |

## Verification
The load strobe and a decoded encoder step can land on the same clock edge. The step then reaches the counter four edges after the pin change. The bench raises the strobe in exactly that cycle and expects the loaded value, with no wrap pulse, both from a per-cycle behavioural model and from a fixed expected number. A second collision, an index clear together with a step in the same edge, arises whenever the index pulse overlaps phase activity. The model resolves it by the same priority, and the comparison against the model judges it on every clock.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;
  typedef enum logic [1:0] {
    DEC_X1  = 2'd0,
    DEC_X2  = 2'd1,
    DEC_X4  = 2'd2,
    DEC_OFF = 2'd3
  } dec_mode_e;

  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_IDX = 2;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/qdec_sync_filter.sv
`timescale 1ns/1ps
module qdec_sync_filter #(
  parameter int CH        = 3,
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 10,
  parameter int STABLE    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    raw,
  input  logic             bypass,
  input  logic [SEL_W-1:0] div_sel,
  output logic [CH-1:0]    clean
);
  localparam int PRE_W = MAX_SHIFT + 1;
  localparam int HW    = STABLE - 1;

  logic [CH-1:0]    sync1, sync2;
  logic [PRE_W-1:0] pre, lim;
  logic [SEL_W-1:0] shift;
  logic             tick;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  // divided sample enable, 1:2^n
  always_comb begin
    shift = (div_sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : div_sel;
    lim   = (PRE_W'(1) << shift) - PRE_W'(1);
    tick  = (pre >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (tick) pre <= '0;
    else pre <= pre + PRE_W'(1);
  end

  for (genvar ch = 0; ch < CH; ch++) begin : g_ch
    logic [HW-1:0] hist;
    logic          agree;

    assign agree = (&{hist, sync2[ch]}) | ~(|{hist, sync2[ch]});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist      <= '0;
        clean[ch] <= 1'b0;
      end else begin
        if (tick) hist <= {hist[HW-2:0], sync2[ch]};
        if (bypass) clean[ch] <= sync2[ch];
        else if (tick && agree) clean[ch] <= sync2[ch];
      end
    end

    // R10: with the filter in path the cleaned level only moves on a sample tick
    a_r10_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bypass) && (clean[ch] != $past(clean[ch]))) |-> $past(tick));
  end
endmodule

// File: rtl/qdec_phase_decode.sv
`timescale 1ns/1ps
module qdec_phase_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       idx_in,
  input  logic       swap,
  input  logic       timer_mode,
  input  logic [1:0] mode,
  input  logic       dir_src_reg,
  input  logic       dir_set_up,
  output logic       step,
  output logic       cnt_up,
  output logic       idx_rise,
  output logic       dir_up
);
  logic a, b, a_q, b_q, i_q;
  logic step_raw, sdir, dir_dec;

  always_comb begin
    a    = swap ? b_in : a_in;
    b    = swap ? a_in : b_in;
    sdir = ~(a_q ^ b);
    step_raw = 1'b0;
    if (timer_mode) begin
      step_raw = a & ~a_q;
      sdir     = b;
    end else begin
      case (dec_mode_e'(mode))
        DEC_X1:  step_raw = a & ~a_q;
        DEC_X2:  step_raw = a ^ a_q;
        DEC_X4:  step_raw = (a ^ a_q) ^ (b ^ b_q);
        default: step_raw = 1'b0;
      endcase
    end
  end

  assign step     = step_raw & ~soft_rst;
  assign idx_rise = idx_in & ~i_q & ~soft_rst;
  assign cnt_up   = dir_src_reg ? dir_set_up : sdir;
  assign dir_up   = dir_src_reg ? dir_set_up : dir_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      i_q     <= 1'b0;
      dir_dec <= 1'b1;
    end else begin
      a_q <= a;
      b_q <= b;
      i_q <= idx_in;
      if (soft_rst) dir_dec <= 1'b1;
      else if (step_raw) dir_dec <= sdir;
    end
  end

  // R1: the reserved decode setting never produces a step
  a_r1_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && mode == 2'd3) |-> !step);
endmodule

// File: rtl/qdec_pos_counter.sv
`timescale 1ns/1ps
module qdec_pos_counter #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             step,
  input  logic             cnt_up,
  input  logic             idx_rise,
  input  logic             idx_clear_en,
  input  logic             narrow16,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] max_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] pos,
  output logic             wrap_pulse,
  output logic             match_pulse
);
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] mask, extreme, pos_m, nxt;
  logic             hit_ext;

  always_comb begin
    mask    = narrow16 ? NARROW_MASK : '1;
    extreme = idx_clear_en ? mask : (max_val & mask);
    pos_m   = pos & mask;
    nxt     = pos;
    hit_ext = 1'b0;
    if (load_stb) begin
      nxt = load_val & mask;
    end else if (idx_clear_en && idx_rise) begin
      nxt = '0;
    end else if (step) begin
      if (cnt_up) begin
        if (pos_m == extreme) begin
          nxt     = '0;
          hit_ext = 1'b1;
        end else begin
          nxt = (pos_m + CNT_W'(1)) & mask;
        end
      end else begin
        if (pos_m == '0) begin
          nxt     = extreme;
          hit_ext = 1'b1;
        end else begin
          nxt = (pos_m - CNT_W'(1)) & mask;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos         <= '0;
      wrap_pulse  <= 1'b0;
      match_pulse <= 1'b0;
    end else if (soft_rst) begin
      pos         <= '0;
      wrap_pulse  <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      pos         <= nxt;
      wrap_pulse  <= hit_ext;
      match_pulse <= (nxt != pos) && (nxt == (match_val & mask));
    end
  end

  // R11: soft reset leaves a zero count and quiet flags
  a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (pos == '0 && !wrap_pulse && !match_pulse));
  // R8: a load always lands, whatever else happened that cycle
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_stb) && !$past(soft_rst)) |-> (pos == ($past(load_val) & $past(mask))));
  // R7: narrow mode keeps the upper bits clear after any update
  a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(narrow16) && ($past(load_stb) || $past(step)) && !$past(soft_rst))
      |-> (pos[CNT_W-1:NARROW_W] == '0));
  // R5: a wrap flag only comes with the count at one of its extremes
  a_r5_wrap_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (pos == '0 || pos == $past(extreme)));
endmodule

// File: rtl/qdec_position.sv
`timescale 1ns/1ps
module qdec_position
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NARROW_W    = 16,
  parameter int DIV_SEL_W   = 4,
  parameter int DIV_MAX     = 10,
  parameter int FILT_STABLE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 enc_idx,
  input  logic                 filt_bypass,
  input  logic [DIV_SEL_W-1:0] filt_div,
  input  logic                 swap_ab,
  input  logic                 timer_mode,
  input  logic [1:0]           dec_mode,
  input  logic                 dir_src_reg,
  input  logic                 dir_set_up,
  input  logic                 idx_clear_en,
  input  logic                 narrow16,
  input  logic                 load_stb,
  input  logic [CNT_W-1:0]     load_val,
  input  logic [CNT_W-1:0]     max_val,
  input  logic [CNT_W-1:0]     match_val,
  output logic [CNT_W-1:0]     pos_cnt,
  output logic                 wrap_pulse,
  output logic                 match_pulse,
  output logic                 dir_up
);
  logic [NUM_CH-1:0] raw, clean;
  logic              step, cnt_up, idx_rise;

  always_comb begin
    raw         = '0;
    raw[CH_A]   = enc_a;
    raw[CH_B]   = enc_b;
    raw[CH_IDX] = enc_idx;
  end

  qdec_sync_filter #(
    .CH(NUM_CH), .SEL_W(DIV_SEL_W), .MAX_SHIFT(DIV_MAX), .STABLE(FILT_STABLE)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .raw(raw), .bypass(filt_bypass),
    .div_sel(filt_div), .clean(clean)
  );

  qdec_phase_decode u_decode (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .a_in(clean[CH_A]), .b_in(clean[CH_B]), .idx_in(clean[CH_IDX]),
    .swap(swap_ab), .timer_mode(timer_mode), .mode(dec_mode),
    .dir_src_reg(dir_src_reg), .dir_set_up(dir_set_up),
    .step(step), .cnt_up(cnt_up), .idx_rise(idx_rise), .dir_up(dir_up)
  );

  qdec_pos_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .step(step), .cnt_up(cnt_up), .idx_rise(idx_rise),
    .idx_clear_en(idx_clear_en), .narrow16(narrow16),
    .load_stb(load_stb), .load_val(load_val), .max_val(max_val),
    .match_val(match_val), .pos(pos_cnt),
    .wrap_pulse(wrap_pulse), .match_pulse(match_pulse)
  );
endmodule

// File: tb/test_qdec_position.sv
`timescale 1ns/1ps
module test_qdec_position;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, enc_a, enc_b, enc_idx;
  logic        filt_bypass, swap_ab, timer_mode, dir_src_reg, dir_set_up;
  logic        idx_clear_en, narrow16, load_stb;
  logic [3:0]  filt_div;
  logic [1:0]  dec_mode;
  logic [31:0] load_val, max_val, match_val, pos_cnt;
  logic        wrap_pulse, match_pulse, dir_up;

  int    checks = 0;
  int    errors = 0;
  int    n_wrap = 0;
  int    n_match = 0;
  int    g = 0;
  bit    done = 1'b0;
  string cur_tag = "R13";

  always #10 clk = ~clk;

  qdec_position i_qdec_position (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .filt_bypass(filt_bypass), .filt_div(filt_div), .swap_ab(swap_ab),
    .timer_mode(timer_mode), .dec_mode(dec_mode),
    .dir_src_reg(dir_src_reg), .dir_set_up(dir_set_up),
    .idx_clear_en(idx_clear_en), .narrow16(narrow16),
    .load_stb(load_stb), .load_val(load_val), .max_val(max_val),
    .match_val(match_val), .pos_cnt(pos_cnt),
    .wrap_pulse(wrap_pulse), .match_pulse(match_pulse), .dir_up(dir_up)
  );

  // behavioural reference, advanced once per rising edge
  logic [2:0]  m_s1, m_s2, m_cl;
  logic [1:0]  m_h [0:2];
  int          m_pre;
  logic        m_pa, m_pb, m_pi, m_dd, m_wr, m_mt;
  logic [31:0] m_pos;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_cl = 0; m_pre = 0;
      for (int c = 0; c < 3; c++) m_h[c] = 0;
      m_pa = 0; m_pb = 0; m_pi = 0; m_dd = 1; m_wr = 0; m_mt = 0; m_pos = 0;
    end else begin : model
      logic a, b, ix, st, sd, ir, hit, cdir, tk;
      logic [31:0] msk, ext, pm, nx;
      logic [2:0] ncl;
      int sh, lim;
      a  = swap_ab ? m_cl[1] : m_cl[0];
      b  = swap_ab ? m_cl[0] : m_cl[1];
      ix = m_cl[2];
      sd = ~(m_pa ^ b);
      if (timer_mode) begin st = a & ~m_pa; sd = b; end
      else case (dec_mode)
        2'd0: st = a & ~m_pa;
        2'd1: st = a ^ m_pa;
        2'd2: st = (a ^ m_pa) ^ (b ^ m_pb);
        default: st = 1'b0;
      endcase
      ir   = ix & ~m_pi;
      cdir = dir_src_reg ? dir_set_up : sd;
      msk  = narrow16 ? 32'h0000FFFF : 32'hFFFFFFFF;
      ext  = idx_clear_en ? msk : (max_val & msk);
      pm   = m_pos & msk;
      nx   = m_pos; hit = 0;
      if (load_stb) nx = load_val & msk;
      else if (idx_clear_en && ir) nx = 0;
      else if (st) begin
        if (cdir) begin
          if (pm == ext) begin nx = 0; hit = 1; end else nx = (pm + 1) & msk;
        end else begin
          if (pm == 0) begin nx = ext; hit = 1; end else nx = (pm - 1) & msk;
        end
      end
      if (soft_rst) begin
        m_pos = 0; m_wr = 0; m_mt = 0; m_dd = 1;
      end else begin
        m_mt = (nx != m_pos) && (nx == (match_val & msk));
        m_wr = hit; m_pos = nx;
        if (st) m_dd = sd;
      end
      m_pa = a; m_pb = b; m_pi = ix;
      sh  = (filt_div > 10) ? 10 : int'(filt_div);
      lim = (1 << sh) - 1;
      tk  = (m_pre >= lim);
      m_pre = tk ? 0 : m_pre + 1;
      ncl = m_cl;
      for (int c = 0; c < 3; c++) begin
        if (filt_bypass) ncl[c] = m_s2[c];
        else if (tk && m_h[c][0] == m_s2[c] && m_h[c][1] == m_s2[c]) ncl[c] = m_s2[c];
        if (tk) m_h[c] = {m_h[c][0], m_s2[c]};
      end
      m_cl = ncl;
      m_s2 = m_s1;
      m_s1 = {enc_idx, enc_b, enc_a};
    end
    #5;
    if (rst_n && !done) begin
      checks++;
      if (pos_cnt !== m_pos || wrap_pulse !== m_wr || match_pulse !== m_mt ||
          dir_up !== (dir_src_reg ? dir_set_up : m_dd)) begin
        errors++;
        $display("FAIL %s per-cycle: actual pos=%h wrap=%b match=%b dir=%b expected pos=%h wrap=%b match=%b dir=%b",
                 cur_tag, pos_cnt, wrap_pulse, match_pulse, dir_up,
                 m_pos, m_wr, m_mt, (dir_src_reg ? dir_set_up : m_dd));
      end
      if (wrap_pulse === 1'b1) n_wrap++;
      if (match_pulse === 1'b1) n_match++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quad(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      g = up ? (g + 1) % 4 : (g + 3) % 4;
      enc_a = (g == 1 || g == 2);
      enc_b = (g == 2 || g == 3);
      waitn(5);
    end
    waitn(3);
  endtask

  task automatic tpulse(input bit dir_level);
    enc_b = dir_level; waitn(4);
    enc_a = 1'b1;      waitn(6);
    enc_a = 1'b0;      waitn(6);
  endtask

  task automatic do_load(input logic [31:0] v);
    load_val = v; load_stb = 1'b1; waitn(1); load_stb = 1'b0; waitn(2);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; enc_a = 0; enc_b = 0; enc_idx = 0;
    filt_bypass = 1; filt_div = 0; swap_ab = 0; timer_mode = 0;
    dec_mode = 2'd2; dir_src_reg = 0; dir_set_up = 0; idx_clear_en = 0;
    narrow16 = 0; load_stb = 0; load_val = 0; max_val = 1000; match_val = 500;
    waitn(3);
    rst_n = 1;
    waitn(2);
    cur_tag = "R13";
    chk("R13 reset count", pos_cnt, 0);
    chk("R13 reset pulses", {30'd0, wrap_pulse, match_pulse}, 0);
    chk("R13 reset dir", {31'd0, dir_up}, 1);

    cur_tag = "R1";
    quad(8, 1); chk("R1 4x up", pos_cnt, 8); chk("R1 dir up", {31'd0, dir_up}, 1);
    quad(4, 0); chk("R1 4x down", pos_cnt, 4); chk("R1 dir down", {31'd0, dir_up}, 0);
    dec_mode = 2'd1; do_load(0);
    quad(8, 1); chk("R1 2x up", pos_cnt, 4);
    dec_mode = 2'd0; do_load(0);
    quad(8, 1); chk("R1 1x up", pos_cnt, 2);
    quad(8, 0); chk("R1 1x down", pos_cnt, 0);
    dec_mode = 2'd3; do_load(20);
    quad(8, 1); chk("R1 reserved idle", pos_cnt, 20);

    cur_tag = "R2";
    dec_mode = 2'd2; swap_ab = 1; do_load(10);
    quad(4, 1); chk("R2 swapped counts down", pos_cnt, 6);
    swap_ab = 0;

    cur_tag = "R3";
    dir_src_reg = 1; dir_set_up = 0; waitn(1);
    chk("R3 dir pin follows forced", {31'd0, dir_up}, 0);
    quad(4, 1); chk("R3 forced down", pos_cnt, 2);
    dir_set_up = 1; waitn(1);
    chk("R3 dir pin forced up", {31'd0, dir_up}, 1);
    dir_src_reg = 0;

    cur_tag = "R4";
    timer_mode = 1; do_load(50);
    tpulse(1); tpulse(1); tpulse(1);
    chk("R4 timer up", pos_cnt, 53);
    tpulse(0); tpulse(0);
    chk("R4 timer down", pos_cnt, 51);
    enc_b = 1; waitn(8); enc_b = 0; waitn(8);
    chk("R4 B edges ignored", pos_cnt, 51);

    cur_tag = "R12";
    enc_b = 1; waitn(4);
    @(negedge clk) enc_a = 1'b1;
    repeat (3) @(posedge clk);
    #5 chk("R12 not before fourth edge", pos_cnt, 51);
    @(posedge clk);
    #5 chk("R12 at fourth edge", pos_cnt, 52);
    waitn(4); enc_a = 0; waitn(6);

    cur_tag = "R5";
    max_val = 5; do_load(4); n_wrap = 0;
    tpulse(1); tpulse(1);
    chk("R5 up wrap to zero", pos_cnt, 0);
    tpulse(0);
    chk("R5 down wrap to max", pos_cnt, 5);
    chk("R5 wrap pulse count", n_wrap, 2);

    cur_tag = "R6";
    idx_clear_en = 1; do_load(100); n_wrap = 0;
    enc_idx = 1; waitn(6); enc_idx = 0; waitn(6);
    chk("R6 index clears", pos_cnt, 0);
    chk("R6 no wrap on index", n_wrap, 0);
    tpulse(0);
    chk("R6 full-width extreme", pos_cnt, 32'hFFFFFFFF);

    cur_tag = "R7";
    narrow16 = 1; do_load(32'h12345678);
    chk("R7 narrow load", pos_cnt, 32'h00005678);
    do_load(0); tpulse(0);
    chk("R7 narrow down wrap", pos_cnt, 32'h0000FFFF);
    narrow16 = 0; idx_clear_en = 0; max_val = 1000;

    cur_tag = "R8";
    do_load(60); enc_b = 1; waitn(2);
    enc_a = 1'b1;
    waitn(3);
    load_val = 42; load_stb = 1'b1;
    waitn(1); load_stb = 1'b0; waitn(3);
    chk("R8 load beats step", pos_cnt, 42);
    enc_a = 0; waitn(6);

    cur_tag = "R9";
    match_val = 7; do_load(5); n_match = 0;
    tpulse(1); tpulse(1);
    chk("R9 reaches match", pos_cnt, 7);
    chk("R9 one match pulse", n_match, 1);
    match_val = 500;

    cur_tag = "R10";
    filt_bypass = 0; filt_div = 2; enc_b = 1; do_load(30); waitn(20);
    enc_a = 1; waitn(3); enc_a = 0; waitn(30);
    chk("R10 glitch rejected", pos_cnt, 30);
    enc_a = 1; waitn(40); enc_a = 0; waitn(40);
    chk("R10 stable edge accepted", pos_cnt, 31);
    filt_div = 4'd15; enc_a = 1; waitn(3); enc_a = 0; waitn(40);
    chk("R10 clamped divider rejects glitch", pos_cnt, 31);
    filt_div = 0; filt_bypass = 1; waitn(10);

    cur_tag = "R11";
    tpulse(0);
    chk("R11 pre dir down", {31'd0, dir_up}, 0);
    soft_rst = 1; waitn(1); soft_rst = 0; waitn(1);
    chk("R11 soft clear count", pos_cnt, 0);
    chk("R11 soft dir up", {31'd0, dir_up}, 1);
    enc_b = 0; timer_mode = 0; waitn(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule